// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects interrupt sources for a CPU on two channels. The normal channel has 16 inputs and the fast channel has 8. Each input has its own trigger mode: rising edge or high level. A detected request is held as pending. Each channel computes the lowest-numbered pending source that is enabled and not already in service. That source's number is held in the channel's vector register, and the channel's request line to the CPU is driven high while such a source exists.

Software reaches the block over a simple register bus with one access per cycle. Each vector register answers at two addresses:

- A read at the acknowledge address returns the vector. It also marks that source in service and clears its pending bit if the source is edge-triggered.
- A read at the inspection address returns the same value and changes nothing, so a debugger can look at it.

An end-of-interrupt write with the source number releases the in-service hold. The two highest fast-channel inputs have no pins of their own. Each is fed by a normal-channel input picked with a 4-bit selector, so software can promote any normal source to the fast channel. Normal inputs 7 and 14 are reserved and can never become pending.

Top module: `vic_ctrl`

## Requirements
- R1: After reset both vector registers read 0x8000_0000 (the "none" code: bit 31 set, index field zero) and both request lines are low.
- R2: An input in edge mode (trigger bit 0) becomes pending on a rising edge, even one lasting a single clock. The pending bit stays set after the input falls. The request line rises on the second clock edge after the input goes high.
- R3: An input in level mode (trigger bit 1) has a pending bit that follows the input, and an acknowledge does not clear it. At reset, normal input 8 is in level mode and every other input is in edge mode.
- R4: An input whose enable bit is 0 gives no request and never appears in the vector, but it still latches pending. Setting its enable bit later makes it appear. At reset every enable bit is 0.
- R5: The vector holds the lowest index among sources that are pending, enabled and not in service. The index is in bits [3:0] for the normal channel and bits [2:0] for the fast channel, and bit 31 is 0.
- R6: A read at the acknowledge address (normal 0x0, fast 0x2) returns the current vector. If that vector is not "none", the read marks the source in service and clears its edge-mode pending bit. The next eligible source then takes its place.
- R7: A read at the inspection address (normal 0x1, fast 0x3) returns the vector and changes no pending or in-service state.
- R8: A write of a source number to the end-of-interrupt register (normal 0x9, fast 0xA) clears that source's in-service mark. Until then the source is held off the vector and the request line, even if it is pending again.
- R9: Normal inputs 7 and 14 never become pending in either trigger mode.
- R10: Fast inputs 6 and 7 are driven by the normal-channel inputs chosen by the route register at 0x8. Bits [3:0] pick the source for fast input 6 and bits [7:4] pick the source for fast input 7. At reset both selectors are 0.
- R11: The configuration registers read back what was written. They are: normal enable 0x4, normal trigger 0x5, fast enable 0x6, fast trigger 0x7 and route 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 16 | Normal-channel interrupt inputs |
| fiq_src | input | 6 | Fast-channel inputs 0 to 5 |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| irq_req | output | 1 | Normal-channel request to the CPU |
| fiq_req | output | 1 | Fast-channel request to the CPU |

## Verification
The bench builds the block with its default parameters: 16 normal inputs, 8 fast inputs and two routed inputs, with reserved positions 7 and 14 and level mode at reset on input 8. With these values the bench can reach the following cases:

- a routed selector that names any of the 16 normal sources;
- a reserved position that sits between live sources in the priority order;
- a reset-default level input next to edge inputs.

The directed scenarios cover several things. They acknowledge sources in a chain through simultaneous edges and re-raise an in-service source before its end-of-interrupt. They also compare inspection reads against acknowledge reads of the same vector.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int DATA_W = 32;
  localparam int REG_AW = 4;

  // Register word addresses; the two vector reads per channel share a value
  // but differ in side effects.
  localparam logic [REG_AW-1:0] A_IRQ_ACK  = 4'h0;
  localparam logic [REG_AW-1:0] A_IRQ_PEEK = 4'h1;
  localparam logic [REG_AW-1:0] A_FIQ_ACK  = 4'h2;
  localparam logic [REG_AW-1:0] A_FIQ_PEEK = 4'h3;
  localparam logic [REG_AW-1:0] A_IRQ_EN   = 4'h4;
  localparam logic [REG_AW-1:0] A_IRQ_TRIG = 4'h5;
  localparam logic [REG_AW-1:0] A_FIQ_EN   = 4'h6;
  localparam logic [REG_AW-1:0] A_FIQ_TRIG = 4'h7;
  localparam logic [REG_AW-1:0] A_ROUTE    = 4'h8;
  localparam logic [REG_AW-1:0] A_IRQ_EOI  = 4'h9;
  localparam logic [REG_AW-1:0] A_FIQ_EOI  = 4'hA;

  // Vector code for "nothing eligible": top bit set, index zero.
  localparam logic [DATA_W-1:0] VEC_NONE = {1'b1, {(DATA_W-1){1'b0}}};
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic level_mode,
  input  logic ack,
  input  logic eoi,
  output logic pend,
  output logic insvc
);
  logic src_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_d <= 1'b0;
      pend  <= 1'b0;
      insvc <= 1'b0;
    end else begin
      src_d <= src;
      if (level_mode)
        pend <= src;
      else if (src && !src_d)
        pend <= 1'b1;
      else if (ack)
        pend <= 1'b0;
      if (ack)
        insvc <= 1'b1;
      else if (eoi)
        insvc <= 1'b0;
    end
  end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_channel.sv
module vic_channel
  import vic_pkg::*;
#(
  parameter int          N        = 16,
  parameter logic [N-1:0] RES_MASK = '0,
  localparam int         IDX_W    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      src,
  input  logic [N-1:0]      en,
  input  logic [N-1:0]      trig,
  input  logic              ack_rd,
  input  logic              eoi_wr,
  input  logic [IDX_W-1:0]  eoi_idx,
  output logic [DATA_W-1:0] vec_q,
  output logic              req_q,
  output logic [N-1:0]      pend,
  output logic [N-1:0]      insvc
);
  logic             vec_none;
  logic [IDX_W-1:0] vec_idx;
  logic [N-1:0]     cand;
  logic             found;
  logic [IDX_W-1:0] win_idx;

  assign vec_none = vec_q[DATA_W-1];
  assign vec_idx  = vec_q[IDX_W-1:0];

  for (genvar i = 0; i < N; i++) begin : g_src
    if (RES_MASK[i]) begin : g_res
      assign pend[i]  = 1'b0;
      assign insvc[i] = 1'b0;
    end else begin : g_live
      vic_src_cell u_cell (
        .clk       (clk),
        .rst       (rst),
        .src       (src[i]),
        .level_mode(trig[i]),
        .ack       (ack_rd && !vec_none && (vec_idx == IDX_W'(i))),
        .eoi       (eoi_wr && (eoi_idx == IDX_W'(i))),
        .pend      (pend[i]),
        .insvc     (insvc[i])
      );
    end
  end

  assign cand = pend & en & ~insvc;

  vic_prio_enc #(.N(N), .IDX_W(IDX_W)) u_enc (
    .req  (cand),
    .found(found),
    .idx  (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= VEC_NONE;
      req_q <= 1'b0;
    end else begin
      vec_q <= found ? DATA_W'(win_idx) : VEC_NONE;
      req_q <= found;
    end
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int               N_IRQ       = 16,
  parameter int               N_FIQ       = 8,
  parameter int               N_ROUTE     = 2,
  parameter logic [N_IRQ-1:0] IRQ_RES     = 16'h4080,
  parameter logic [N_IRQ-1:0] IRQ_LVL_RST = 16'h0100,
  parameter logic [N_FIQ-1:0] FIQ_LVL_RST = '0,
  localparam int              SEL_W       = $clog2(N_IRQ),
  localparam int              IRQ_IW      = $clog2(N_IRQ),
  localparam int              FIQ_IW      = $clog2(N_FIQ),
  localparam int              N_FPIN      = N_FIQ - N_ROUTE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_IRQ-1:0]   irq_src,
  input  logic [N_FPIN-1:0]  fiq_src,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_req,
  output logic               fiq_req
);
  logic [N_IRQ-1:0]  irq_en_q, irq_trig_q, irq_pend, irq_insvc;
  logic [N_FIQ-1:0]  fiq_en_q, fiq_trig_q, fiq_pend, fiq_insvc, fiq_in;
  logic [SEL_W-1:0]  route_q [N_ROUTE];
  logic [DATA_W-1:0] route_rd, irq_vec, fiq_vec;
  logic              rd, wr;
  logic              irq_ack_rd, irq_peek_rd, fiq_ack_rd, irq_eoi_wr, fiq_eoi_wr;

  assign rd          = bus_en && !bus_we;
  assign wr          = bus_en && bus_we;
  assign irq_ack_rd  = rd && (bus_addr == A_IRQ_ACK);
  assign irq_peek_rd = rd && (bus_addr == A_IRQ_PEEK);
  assign fiq_ack_rd  = rd && (bus_addr == A_FIQ_ACK);
  assign irq_eoi_wr  = wr && (bus_addr == A_IRQ_EOI);
  assign fiq_eoi_wr  = wr && (bus_addr == A_FIQ_EOI);

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q   <= '0;
      irq_trig_q <= IRQ_LVL_RST;
      fiq_en_q   <= '0;
      fiq_trig_q <= FIQ_LVL_RST;
    end else if (wr) begin
      case (bus_addr)
        A_IRQ_EN:   irq_en_q   <= bus_wdata[N_IRQ-1:0];
        A_IRQ_TRIG: irq_trig_q <= bus_wdata[N_IRQ-1:0];
        A_FIQ_EN:   fiq_en_q   <= bus_wdata[N_FIQ-1:0];
        A_FIQ_TRIG: fiq_trig_q <= bus_wdata[N_FIQ-1:0];
        default: ;
      endcase
    end
  end

  // Routed fast inputs: each selector picks one normal-channel input
  assign fiq_in[N_FPIN-1:0] = fiq_src;
  for (genvar k = 0; k < N_ROUTE; k++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst)
        route_q[k] <= '0;
      else if (wr && bus_addr == A_ROUTE)
        route_q[k] <= bus_wdata[k*SEL_W +: SEL_W];
    end
    assign fiq_in[N_FPIN+k]             = irq_src[route_q[k]];
    assign route_rd[k*SEL_W +: SEL_W]   = route_q[k];
  end
  assign route_rd[DATA_W-1:N_ROUTE*SEL_W] = '0;

  vic_channel #(.N(N_IRQ), .RES_MASK(IRQ_RES)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .src    (irq_src),
    .en     (irq_en_q),
    .trig   (irq_trig_q),
    .ack_rd (irq_ack_rd),
    .eoi_wr (irq_eoi_wr),
    .eoi_idx(bus_wdata[IRQ_IW-1:0]),
    .vec_q  (irq_vec),
    .req_q  (irq_req),
    .pend   (irq_pend),
    .insvc  (irq_insvc)
  );

  vic_channel #(.N(N_FIQ), .RES_MASK('0)) u_fiq (
    .clk    (clk),
    .rst    (rst),
    .src    (fiq_in),
    .en     (fiq_en_q),
    .trig   (fiq_trig_q),
    .ack_rd (fiq_ack_rd),
    .eoi_wr (fiq_eoi_wr),
    .eoi_idx(bus_wdata[FIQ_IW-1:0]),
    .vec_q  (fiq_vec),
    .req_q  (fiq_req),
    .pend   (fiq_pend),
    .insvc  (fiq_insvc)
  );

  // Registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (bus_addr)
        A_IRQ_ACK, A_IRQ_PEEK: bus_rdata <= irq_vec;
        A_FIQ_ACK, A_FIQ_PEEK: bus_rdata <= fiq_vec;
        A_IRQ_EN:   bus_rdata <= DATA_W'(irq_en_q);
        A_IRQ_TRIG: bus_rdata <= DATA_W'(irq_trig_q);
        A_FIQ_EN:   bus_rdata <= DATA_W'(fiq_en_q);
        A_FIQ_TRIG: bus_rdata <= DATA_W'(fiq_trig_q);
        A_ROUTE:    bus_rdata <= route_rd;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int               N_IRQ   = 16,
  parameter logic [N_IRQ-1:0] IRQ_RES = 16'h4080,
  localparam int              IW      = $clog2(N_IRQ)
) (
  input logic             clk,
  input logic             rst,
  input logic [N_IRQ-1:0] irq_src,
  input logic [N_IRQ-1:0] irq_en_q,
  input logic [N_IRQ-1:0] irq_trig_q,
  input logic [N_IRQ-1:0] irq_pend,
  input logic [N_IRQ-1:0] irq_insvc,
  input logic [31:0]      irq_vec,
  input logic             irq_req,
  input logic             irq_ack_rd,
  input logic             irq_peek_rd
);
  logic [N_IRQ-1:0] cand_q;
  logic [N_IRQ-1:0] lower_m;
  logic [IW-1:0]    vidx;

  assign vidx    = irq_vec[IW-1:0];
  assign lower_m = (N_IRQ'(1) << vidx) - N_IRQ'(1);

  always_ff @(posedge clk) begin
    if (rst) cand_q <= '0;
    else     cand_q <= irq_pend & irq_en_q & ~irq_insvc;
  end

  // R1
  reset_none_chk: assert property (@(posedge clk)
    rst |=> (irq_vec == 32'h8000_0000 && !irq_req));

  // R5
  vec_prio_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_vec[31] |-> (cand_q[vidx] && ((cand_q & lower_m) == '0)));

  // R6
  ack_insvc_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_rd && !irq_vec[31]) |=> irq_insvc[$past(vidx)]);

  // R7
  peek_still_chk: assert property (@(posedge clk) disable iff (rst)
    irq_peek_rd |=> $stable(irq_insvc));

  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((irq_pend & $past(irq_trig_q)) ==
                     ($past(irq_src) & $past(irq_trig_q) & ~IRQ_RES)));

  // R9
  reserved_vec_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_vec[31] |-> !IRQ_RES[vidx]);
endmodule

bind vic_ctrl vic_ctrl_chk #(.N_IRQ(N_IRQ), .IRQ_RES(IRQ_RES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_src    (irq_src),
  .irq_en_q   (irq_en_q),
  .irq_trig_q (irq_trig_q),
  .irq_pend   (irq_pend),
  .irq_insvc  (irq_insvc),
  .irq_vec    (irq_vec),
  .irq_req    (irq_req),
  .irq_ack_rd (irq_ack_rd),
  .irq_peek_rd(irq_peek_rd)
);

// File: tb/vic_ctrl_tb.sv
module vic_ctrl_tb;
  localparam logic [31:0] NONE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_src = '0;
  logic [5:0]  fiq_src = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req, fiq_req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vic_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_src(irq_src), .fiq_src(fiq_src),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_irq(input logic [15:0] m);
    @(negedge clk); irq_src = irq_src | m;
    @(negedge clk); irq_src = irq_src & ~m;
    @(negedge clk);
  endtask

  task automatic drain();
    logic [31:0] v;
    for (int i = 0; i < 20; i++) begin
      rd(4'h0, v);
      if (v[31]) break;
      wr(4'h9, v);
    end
    for (int i = 0; i < 10; i++) begin
      rd(4'h2, v);
      if (v[31]) break;
      wr(4'hA, v);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq_req", {31'b0, irq_req}, 32'd0);
    chk("R1 fiq_req", {31'b0, fiq_req}, 32'd0);
    rd(4'h1, v); chk("R1 irq vector", v, NONE);
    rd(4'h3, v); chk("R1 fiq vector", v, NONE);
    rd(4'h5, v); chk("R3 irq trig reset", v, 32'h0100);
    rd(4'h4, v); chk("R4 irq enable reset", v, 32'h0);
    rd(4'h8, v); chk("R10 route reset", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(4'h4, 32'h0000_FFFF); rd(4'h4, v); chk("R11 irq enable", v, 32'hFFFF);
    wr(4'h6, 32'h0000_00FF); rd(4'h6, v); chk("R11 fiq enable", v, 32'hFF);
    wr(4'h7, 32'h0000_00A5); rd(4'h7, v); chk("R11 fiq trig", v, 32'hA5);
    wr(4'h7, 32'h0);
    wr(4'h8, 32'h0000_00C3); rd(4'h8, v); chk("R11 route", v, 32'hC3);
  endtask

  task automatic t_edge_ack_eoi();
    logic [31:0] v;
    @(negedge clk); irq_src[3] = 1'b1;
    @(negedge clk); irq_src[3] = 1'b0;
    chk("R2 req not yet", {31'b0, irq_req}, 32'd0);
    @(negedge clk);
    chk("R2 req two edges later", {31'b0, irq_req}, 32'd1);
    rd(4'h1, v); chk("R7 peek value", v, 32'd3);
    rd(4'h1, v); chk("R7 peek again unchanged", v, 32'd3);
    chk("R7 req kept after peek", {31'b0, irq_req}, 32'd1);
    rd(4'h0, v); chk("R6 ack returns vector", v, 32'd3);
    rd(4'h1, v); chk("R6 after ack none", v, NONE);
    chk("R6 req dropped", {31'b0, irq_req}, 32'd0);
    pulse_irq(16'h0008);
    rd(4'h1, v); chk("R8 held while in service", v, NONE);
    wr(4'h9, 32'd3);
    rd(4'h1, v); chk("R8 released by eoi", v, 32'd3);
    drain();
    rd(4'h1, v); chk("R2 edge consumed", v, NONE);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    pulse_irq(16'h1420);
    rd(4'h1, v); chk("R5 lowest first", v, 32'd5);
    rd(4'h0, v); chk("R6 ack 5", v, 32'd5);
    rd(4'h0, v); chk("R5 next 10", v, 32'd10);
    rd(4'h0, v); chk("R5 next 12", v, 32'd12);
    rd(4'h1, v); chk("R6 chain empty", v, NONE);
    wr(4'h9, 32'd5); wr(4'h9, 32'd10); wr(4'h9, 32'd12);
    rd(4'h1, v); chk("R8 eoi without new edge", v, NONE);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(4'h4, 32'h0000_FFFB);
    pulse_irq(16'h0004);
    chk("R4 masked no req", {31'b0, irq_req}, 32'd0);
    rd(4'h1, v); chk("R4 masked not in vector", v, NONE);
    wr(4'h4, 32'h0000_FFFF);
    rd(4'h1, v); chk("R4 latched while masked", v, 32'd2);
    drain();
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk); irq_src[8] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(4'h1, v); chk("R3 level pending", v, 32'd8);
    rd(4'h0, v); chk("R3 level ack", v, 32'd8);
    rd(4'h1, v); chk("R8 level held in service", v, NONE);
    wr(4'h9, 32'd8);
    rd(4'h1, v); chk("R3 level not cleared by ack", v, 32'd8);
    @(negedge clk); irq_src[8] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 level drop removes req", {31'b0, irq_req}, 32'd0);
    rd(4'h1, v); chk("R3 level drop vector", v, NONE);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    pulse_irq(16'h4080);
    rd(4'h1, v); chk("R9 reserved edge", v, NONE);
    wr(4'h5, 32'h0000_4180);
    @(negedge clk); irq_src[7] = 1'b1; irq_src[14] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(4'h1, v); chk("R9 reserved level", v, NONE);
    chk("R9 no req", {31'b0, irq_req}, 32'd0);
    @(negedge clk); irq_src[7] = 1'b0; irq_src[14] = 1'b0;
    wr(4'h5, 32'h0000_0100);
  endtask

  task automatic t_route();
    logic [31:0] v;
    wr(4'h8, 32'h0000_0019);
    pulse_irq(16'h0200);
    rd(4'h3, v); chk("R10 irq9 onto fiq6", v, 32'd6);
    rd(4'h1, v); chk("R10 irq side still sees 9", v, 32'd9);
    chk("R10 fiq_req", {31'b0, fiq_req}, 32'd1);
    drain();
    pulse_irq(16'h0002);
    rd(4'h3, v); chk("R10 irq1 onto fiq7", v, 32'd7);
    @(negedge clk); fiq_src[0] = 1'b1;
    @(negedge clk); fiq_src[0] = 1'b0;
    @(negedge clk);
    rd(4'h3, v); chk("R5 fiq0 over fiq7", v, 32'd0);
    drain();
    wr(4'h7, 32'h0000_0004);
    @(negedge clk); fiq_src[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(4'h3, v); chk("R3 fiq level", v, 32'd2);
    @(negedge clk); fiq_src[2] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 fiq level drop", {31'b0, fiq_req}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edge_ack_eoi();
    t_priority();
    t_mask();
    t_level();
    t_reserved();
    t_route();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule